// File: doc/BRIEF.md
# Inverted-Line Serial Transceiver with Four Selectable Rates

This block is a full-duplex asynchronous serial transceiver using 8N1 framing. It is meant to be wired directly to a PC-style serial connector with no level-shifting buffer. Because there is no buffer, both line pins use the opposite polarity to a normal logic-level UART. An idle line sits low and a start bit drives the line high. Each data bit is placed on the wire as its complement.

A two-bit rate select picks one of four bit rates: 9600, 19200, 31250 (the MIDI rate) or 38400 bit/s. The bit period is derived from the system clock frequency given as a parameter.

The receiver delivers each good byte with a one-clock strobe. The transmitter takes a byte on a start pulse and holds a busy flag high while the frame is being shifted out.

Top module: `inv_uart`

## Requirements
- R1: After reset, `tx_pin` is low, `tx_busy` is low and `rx_valid` is low.
- R2: One bit lasts round(CLK_HZ/baud) clocks. The baud rate is chosen by `rate_sel` as follows: 0 gives 9600, 1 gives 19200, 2 gives 31250 and 3 gives 38400.
- R3: A transmitted frame has these parts, in this order:
  - a start bit with `tx_pin` high;
  - the 8 data bits, least significant first, each driven as its complement (logic 1 is low on the pin);
  - a stop bit with the pin low.
- R4: `tx_start` is accepted only while `tx_busy` is low. Once accepted, `tx_busy` rises on the next clock and stays high for exactly 10 bit periods. A `tx_start` pulse seen while busy has no effect: no second frame follows.
- R5: The receiver decodes a frame that uses the same inverted format as R3. It then raises `rx_valid` for exactly one clock, with the byte on `rx_data`.
- R6: The start level is sampled again half a bit after the rising edge. A high pulse shorter than half a bit therefore produces no byte, and the receiver stays ready for the next frame.
- R7: After reset, the receiver ignores the line until it has been seen low (idle). A line held high through reset and then released produces no byte.
- R8: A frame whose stop bit is sampled high is discarded: `rx_valid` does not pulse.
- R9: The rate is captured when a frame starts. A change of `rate_sel` in the middle of a frame does not alter that frame's bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 2 | Bit-rate select (see R2) |
| rx_pin | input | 1 | Serial line in, inverted polarity, idle low |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-clock strobe marking a new `rx_data` |
| tx_data | input | 8 | Byte to send |
| tx_start | input | 1 | Request to send `tx_data` |
| tx_busy | output | 1 | Transmitter is shifting a frame |
| tx_pin | output | 1 | Serial line out, inverted polarity, idle low |

## Verification
A receiver state that is off by a bit shows up as a wrong `rx_data` byte, a missing strobe, or a stray strobe. This becomes visible within one frame time, about 10 bit periods. A wrong transmitter count or shift state shows up in two ways:
- the start bit has the wrong length, or `tx_busy` lasts the wrong time, which can be measured to the clock;
- the bits read at their centres are misplaced.

The directed cases are aimed at the internal decisions that are otherwise hidden: the mid-start recheck, the wait for idle after reset, the stop check and rate latching. For each of these, a wrong choice appears at the ports either as a spurious byte or as a bit time of the wrong length.

// File: rtl/inv_uart_pkg.sv
// Shared types and rate arithmetic for the inverted-line transceiver.
// Assumes the clock is at least a few times the highest bit rate.
package inv_uart_pkg;

    // Receiver sequencing states.
    typedef enum logic [2:0] {
        RX_WAIT_IDLE = 3'd0,
        RX_ARMED     = 3'd1,
        RX_START     = 3'd2,
        RX_DATA      = 3'd3,
        RX_STOP      = 3'd4
    } rx_state_e;

    // Baud for each select code; the code order is visible at the pins.
    function automatic int unsigned rate_baud(input int unsigned code);
        case (code)
            0:       return 9600;
            1:       return 19200;
            2:       return 31250;
            default: return 38400;
        endcase
    endfunction

    // Clocks per bit, rounded to nearest.
    function automatic int unsigned bit_ticks(input int unsigned clk_hz,
                                              input int unsigned baud);
        return (clk_hz + baud / 2) / baud;
    endfunction

endpackage

// File: rtl/inv_uart_rate.sv
// Rate table: turns the two-bit select into a clocks-per-bit count.
// Purely combinational; users latch the value at frame start.
module inv_uart_rate #(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned CNT_W  = 13
) (
    input  logic [1:0]       rate_sel,
    output logic [CNT_W-1:0] ticks
);
    localparam int unsigned NRATES = 4;

    logic [CNT_W-1:0] rate_tab [NRATES];

    // One constant entry per select code.
    for (genvar g = 0; g < NRATES; g++) begin : g_tab
        assign rate_tab[g] = CNT_W'(inv_uart_pkg::bit_ticks(CLK_HZ,
                                     inv_uart_pkg::rate_baud(g)));
    end

    // Select the active entry.
    assign ticks = rate_tab[rate_sel];

endmodule

// File: rtl/inv_uart_rx.sv
// Receiver for an inverted 8N1 line (idle low, start high, data complemented).
// Synchronises the pin, waits for idle, rechecks the start at mid-bit,
// samples at bit centres and keeps the byte only on a good (low) stop bit.
// The synchroniser resets to "high" so an active line at reset is not
// taken as idle.
module inv_uart_rx #(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ticks,
    input  logic             rx_pin,
    output logic [7:0]       rx_data,
    output logic             rx_valid
);
    import inv_uart_pkg::*;

    localparam int unsigned NBITS = 8;
    localparam int unsigned BIT_W = $clog2(NBITS);

    logic [1:0]       sync_q;
    logic             line_s;
    rx_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per;
    logic [BIT_W-1:0] bitn;
    logic [7:0]       shreg;

    assign line_s = sync_q[1];

    // Two-flop synchroniser on the input pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_pin};
    end

    // Frame sequencer: start detect, centre sampling, stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_WAIT_IDLE;
            cnt      <= '0;
            per      <= '0;
            bitn     <= '0;
            shreg    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            case (state)
                RX_WAIT_IDLE: begin
                    if (!line_s) state <= RX_ARMED;
                end
                RX_ARMED: begin
                    if (line_s) begin
                        per   <= ticks;
                        cnt   <= (ticks >> 1) - 1'b1;
                        state <= RX_START;
                    end
                end
                RX_START: begin
                    if (cnt == '0) begin
                        if (line_s) begin
                            cnt   <= per - 1'b1;
                            bitn  <= '0;
                            state <= RX_DATA;
                        end else begin
                            state <= RX_ARMED;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == '0) begin
                        shreg <= {~line_s, shreg[7:1]};
                        cnt   <= per - 1'b1;
                        if (bitn == BIT_W'(NBITS - 1)) state <= RX_STOP;
                        else                           bitn  <= bitn + 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == '0) begin
                        if (!line_s) begin
                            rx_data  <= shreg;
                            rx_valid <= 1'b1;
                            state    <= RX_ARMED;
                        end else begin
                            state <= RX_WAIT_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= RX_WAIT_IDLE;
            endcase
        end
    end

    // The byte strobe never lasts more than one clock.
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // While waiting for idle, a high line keeps the receiver parked.
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_WAIT_IDLE && line_s) |=> (state == RX_WAIT_IDLE));

    // A high stop sample never yields a strobe.
    assert_bad_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_STOP && cnt == '0 && line_s) |=> !rx_valid);

endmodule

// File: rtl/inv_uart_tx.sv
// Transmitter for an inverted 8N1 line. Takes a byte when idle, drives
// start (pin high), eight complemented data bits LSB first, then stop (low).
// The bit period is latched at acceptance and held for the whole frame.
module inv_uart_tx #(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ticks,
    input  logic [7:0]       tx_data,
    input  logic             tx_start,
    output logic             tx_busy,
    output logic             tx_pin
);
    localparam int unsigned FRAME = 10;
    localparam int unsigned FCNT_W = $clog2(FRAME);

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  per;
    logic [FCNT_W-1:0] bitn;
    logic [FRAME-1:0]  frame_q;

    // Frame shifter and bit timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_busy <= 1'b0;
            tx_pin  <= 1'b0;
            cnt     <= '0;
            per     <= '0;
            bitn    <= '0;
            frame_q <= '0;
        end else if (!tx_busy) begin
            tx_pin <= 1'b0;
            if (tx_start) begin
                tx_busy <= 1'b1;
                per     <= ticks;
                cnt     <= ticks - 1'b1;
                frame_q <= {1'b1, tx_data, 1'b0};
                bitn    <= '0;
                tx_pin  <= 1'b1;
            end
        end else if (cnt == '0) begin
            if (bitn == FCNT_W'(FRAME - 1)) begin
                tx_busy <= 1'b0;
                tx_pin  <= 1'b0;
            end else begin
                bitn    <= bitn + 1'b1;
                frame_q <= {1'b0, frame_q[FRAME-1:1]};
                tx_pin  <= ~frame_q[1];
                cnt     <= per - 1'b1;
            end
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // An accepted request starts the frame with a high start bit.
    assert_start_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && !tx_busy) |=> (tx_busy && tx_pin));

    // An idle transmitter holds the line low.
    assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> !tx_pin);

    // Within a bit the pin does not move.
    assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && cnt != '0) |=> $stable(tx_pin));

    // A request while busy leaves the frame untouched.
    assert_busy_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && tx_start && cnt != '0) |=> $stable(frame_q));

    // The latched period survives a select change mid-frame.
    assert_rate_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> (!tx_busy || $stable(per)));

endmodule

// File: rtl/inv_uart.sv
// Top of the inverted-line transceiver: one shared rate table feeding an
// independent receiver and transmitter (full duplex).
// Assumes rate_sel changes rarely; each side latches it per frame.
module inv_uart #(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    input  logic       rx_pin,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    input  logic [7:0] tx_data,
    input  logic       tx_start,
    output logic       tx_busy,
    output logic       tx_pin
);
    localparam int unsigned MAX_TICKS =
        inv_uart_pkg::bit_ticks(CLK_HZ, inv_uart_pkg::rate_baud(0));
    localparam int unsigned CNT_W = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] ticks;

    inv_uart_rate #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_rate (
        .rate_sel (rate_sel),
        .ticks    (ticks)
    );

    inv_uart_rx #(.CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ticks    (ticks),
        .rx_pin   (rx_pin),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    inv_uart_tx #(.CNT_W(CNT_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ticks    (ticks),
        .tx_data  (tx_data),
        .tx_start (tx_start),
        .tx_busy  (tx_busy),
        .tx_pin   (tx_pin)
    );

    // Reset leaves both directions quiet.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!tx_busy && !tx_pin && !rx_valid));

endmodule

// File: tb/inv_uart_tb.sv
module inv_uart_tb;
    localparam int unsigned CLK_HZ = 1_920_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       rx_pin = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic [7:0] tx_data = 8'h00;
    logic       tx_start = 1'b0;
    logic       tx_busy;
    logic       tx_pin;

    int checks = 0;
    int failures = 0;
    int rx_cnt = 0;
    logic [7:0] rx_last = 8'h00;
    bit done = 1'b0;

    always #10 clk = ~clk;

    inv_uart #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .rx_pin(rx_pin),
        .rx_data(rx_data), .rx_valid(rx_valid), .tx_data(tx_data),
        .tx_start(tx_start), .tx_busy(tx_busy), .tx_pin(tx_pin)
    );

    // Receive monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_data;
        end
    end

    function automatic int bit_len(input logic [1:0] sel);
        int b;
        case (sel)
            2'd0: b = 9600;
            2'd1: b = 19200;
            2'd2: b = 31250;
            default: b = 38400;
        endcase
        return (CLK_HZ + b / 2) / b;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive one inverted frame on rx_pin.
    task automatic send_rx(input logic [7:0] d, input logic [1:0] sel, input bit bad_stop);
        int p;
        p = bit_len(sel);
        @(negedge clk);
        rx_pin = 1'b1;
        wait_cyc(p);
        for (int i = 0; i < 8; i++) begin
            rx_pin = ~d[i];
            wait_cyc(p);
        end
        rx_pin = bad_stop;
        wait_cyc(p);
        rx_pin = 1'b0;
        wait_cyc(2);
    endtask

    // Send a byte and decode tx_pin at bit centres (R3).
    task automatic tx_check(input logic [7:0] d, input logic [1:0] sel);
        int p;
        logic [9:0] got;
        p = bit_len(sel);
        @(negedge clk);
        tx_data = d;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        wait_cyc(p / 2);
        for (int i = 0; i < 10; i++) begin
            got[i] = tx_pin;
            if (i < 9) wait_cyc(p);
        end
        check(got[0] == 1'b1, "R3 start bit", got[0], 1);
        check(~got[8:1] == d, "R3 data", int'(~got[8:1]), d);
        check(got[9] == 1'b0, "R3 stop bit", got[9], 0);
        wait_cyc(p);
    endtask

    task automatic do_reset(input logic line);
        rx_pin = line;
        rst_n = 1'b0;
        wait_cyc(4);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n0, p, cnt;
        logic [7:0] d;
        logic [1:0] s;
        void'($urandom(32'd1234));
        do_reset(1'b0);
        @(negedge clk);
        // R1
        check(!tx_pin && !tx_busy && !rx_valid, "R1 reset state",
              {tx_pin, tx_busy, rx_valid}, 0);
        wait_cyc(4);

        // R2: start-bit length at each rate (data bit0 = 1 so pin drops after start)
        for (int s2 = 0; s2 < 4; s2++) begin
            rate_sel = 2'(s2);
            @(negedge clk);
            tx_data = 8'h01;
            tx_start = 1'b1;
            @(negedge clk);
            tx_start = 1'b0;
            cnt = 1;
            while (tx_pin) begin
                @(negedge clk);
                if (tx_pin) cnt++;
            end
            check(cnt == bit_len(2'(s2)), "R2 bit period", cnt, bit_len(2'(s2)));
            while (tx_busy) @(negedge clk);
        end

        // R3 directed patterns
        rate_sel = 2'd3;
        tx_check(8'hA5, 2'd3);
        tx_check(8'h00, 2'd3);
        tx_check(8'hFF, 2'd3);

        // R4 and R9: busy length, ignored request, select change mid-frame
        rate_sel = 2'd1;
        p = bit_len(2'd1);
        @(negedge clk);
        tx_data = 8'h3C;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        cnt = 0;
        while (tx_busy) begin
            cnt++;
            if (cnt == 3) begin tx_data = 8'hC3; tx_start = 1'b1; end
            if (cnt == 4) tx_start = 1'b0;
            if (cnt == p) rate_sel = 2'd3;
            @(negedge clk);
        end
        check(cnt == 10 * p, "R4 R9 busy length", cnt, 10 * p);
        n0 = 0;
        for (int i = 0; i < 3 * p; i++) begin
            @(negedge clk);
            if (tx_pin || tx_busy) n0++;
        end
        check(n0 == 0, "R4 no second frame", n0, 0);

        // R5 directed receive
        n0 = rx_cnt;
        send_rx(8'h5A, 2'd3, 1'b0);
        rate_sel = 2'd3;
        check(rx_cnt == n0 + 1 && rx_last == 8'h5A, "R5 rx byte", rx_last, 8'h5A);

        // R6 glitch shorter than half a bit
        rate_sel = 2'd0;
        p = bit_len(2'd0);
        n0 = rx_cnt;
        @(negedge clk);
        rx_pin = 1'b1;
        wait_cyc(p / 4);
        rx_pin = 1'b0;
        wait_cyc(12 * p);
        check(rx_cnt == n0, "R6 glitch ignored", rx_cnt - n0, 0);
        send_rx(8'h81, 2'd0, 1'b0);
        check(rx_cnt == n0 + 1 && rx_last == 8'h81, "R6 rx after glitch", rx_last, 8'h81);

        // R8 bad stop discarded, then good frame
        rate_sel = 2'd2;
        p = bit_len(2'd2);
        n0 = rx_cnt;
        send_rx(8'h66, 2'd2, 1'b1);
        check(rx_cnt == n0, "R8 bad stop dropped", rx_cnt - n0, 0);
        send_rx(8'h99, 2'd2, 1'b0);
        check(rx_cnt == n0 + 1 && rx_last == 8'h99, "R8 rx recovers", rx_last, 8'h99);

        // R7 line high through reset
        rate_sel = 2'd3;
        p = bit_len(2'd3);
        do_reset(1'b1);
        n0 = rx_cnt;
        wait_cyc(3 * p);
        rx_pin = 1'b0;
        wait_cyc(12 * p);
        check(rx_cnt == n0, "R7 no byte before idle", rx_cnt - n0, 0);
        send_rx(8'h47, 2'd3, 1'b0);
        check(rx_cnt == n0 + 1 && rx_last == 8'h47, "R7 rx after idle", rx_last, 8'h47);

        // Random full-duplex traffic (R3, R5)
        for (int k = 0; k < 10; k++) begin
            logic [7:0] d2;
            s = 2'($urandom_range(1, 3));
            d = 8'($urandom);
            d2 = 8'($urandom);
            rate_sel = s;
            n0 = rx_cnt;
            fork
                send_rx(d, s, 1'b0);
                tx_check(d2, s);
            join
            check(rx_cnt == n0 + 1 && rx_last == d, "R5 random rx", rx_last, d);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule